// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer. It counts down in its own slow clock domain and is controlled from a bus clock domain through four small registers. Software drives it only by writing 16-bit key values to a command register. One key opens the prescaler and reload registers for writing. One key starts the countdown. One key refreshes the counter from the reload value. Once the countdown is started it cannot be stopped. If software does not refresh the counter in time, it reaches zero and the block raises a one-cycle reset pulse in the counter clock domain. It then reloads itself and keeps running.

A new prescaler or reload value written on the bus side is passed to the counter domain through a toggle handshake. While that transfer is in flight, a busy flag in the status register is set, and further writes to the same register are dropped. Key commands also cross as single-bit toggles. No multi-bit value is sampled across the two domains while it can change.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the prescaler register (select 1) reads 0, the reload register (select 2) reads 0xFFF, and the status register (select 3) reads 0. `wdt_rst` stays low and the counter is idle.
- R2: Register selects are as follows: 0 is the command register, 1 is the prescaler (bits 2:0), 2 is the reload value (bits 11:0), and 3 is status (bit 0 prescaler busy, bit 1 reload busy). Writes to selects 1 and 2 take effect only after 0x5555 has been written to the command register. Any other command value, including the start and reload keys, locks them again.
- R3: An accepted configuration write sets that register's busy flag from the next bus cycle. A write to a register whose busy flag is set is ignored.
- R4: A busy flag clears by itself once the counter domain has captured the value, within a few counter-clock cycles. The register then reads back the accepted value.
- R5: Only bits 11:0 of a reload write are stored. Bits 15:12 are ignored.
- R6: The prescaler code selects a divide ratio of 4 shifted left by the code. Codes 0..6 give 4, 8, 16, 32, 64, 128 and 256, and code 7 also divides by 256.
- R7: While running with divide ratio D and reload value N, successive `wdt_rst` pulses are exactly D*(N+1) counter-clock cycles apart. Each pulse is one counter-clock cycle wide.
- R8: No `wdt_rst` pulse occurs before 0xCCCC has been written. The reload key alone does not start the counter.
- R9: Writing 0xAAAA reloads the counter from the reload value and restarts the prescaler phase. Writing it at intervals shorter than the timeout prevents any pulse.
- R10: Once started, the counter keeps running whatever values are written to the command register. Only a reset stops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data (combinational) |
| lclk | input | 1 | Counter clock |
| lrst | input | 1 | Synchronous active-high reset, counter domain |
| wdt_rst | output | 1 | One-cycle timeout pulse in the counter domain |

## Verification
The timeout period is swept over every prescaler code, including the clamped code 7, and over more than one reload value. A wrong shift, a missing clamp or an off-by-one in the reload count each gives a distinct pulse spacing. Locked writes, writes issued while a flag is busy, and reload writes with upper bits set are each followed by a read-back, which separates a lock fault from a handshake fault from a width fault. The refresh test, the idle test and the stop-attempt test each compare pulse counts across a window. Together they tell a counter that ignores the reload key from one that starts early or one that can be halted.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int KEY_W     = 16;
    localparam int PSC_W     = 3;
    localparam int DIV_W     = 8;
    localparam int MAX_SHIFT = 6;

    localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_START  = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_RELOAD = 16'hAAAA;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_PSC  = 2'd1,
        SEL_RLD  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        CMD_OTHER,
        CMD_UNLOCK,
        CMD_START,
        CMD_RELOAD
    } cmd_e;

    // One toggle per event crossing from the bus domain to the counter domain
    typedef struct packed {
        logic presc;
        logic rld;
        logic start;
        logic reload;
    } xfer_t;

    localparam int XFER_W = $bits(xfer_t);

    function automatic cmd_e decode_key(input logic [KEY_W-1:0] k);
        case (k)
            KEY_UNLOCK: return CMD_UNLOCK;
            KEY_START:  return CMD_START;
            KEY_RELOAD: return CMD_RELOAD;
            default:    return CMD_OTHER;
        endcase
    endfunction

    // Terminal value of the prescaler counter: (4 << min(code, MAX_SHIFT)) - 1
    function automatic logic [DIV_W-1:0] div_limit(input logic [PSC_W-1:0] code);
        logic [DIV_W:0]     full;
        logic [PSC_W-1:0]   sh;
        sh   = (code > PSC_W'(MAX_SHIFT)) ? PSC_W'(MAX_SHIFT) : code;
        full = (DIV_W+1)'(4) << sh;
        return DIV_W'(full - (DIV_W+1)'(1));
    endfunction

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wdg_bus_regs.sv
module wdg_bus_regs
    import wdg_pkg::*;
#(
    parameter int RLD_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [KEY_W-1:0]   wr_data,
    input  logic [1:0]         rd_sel,
    output logic [KEY_W-1:0]   rd_data,
    input  logic               presc_ack_s,
    input  logic               rld_ack_s,
    output xfer_t              req_tgl,
    output logic [PSC_W-1:0]   presc_sh,
    output logic [RLD_W-1:0]   rld_sh,
    output logic               presc_busy,
    output logic               rld_busy,
    output logic               unlocked
);

    cmd_e cmd;
    logic presc_seen, rld_seen;
    logic presc_done, rld_done;
    logic wr_cmd, wr_psc, wr_rld;

    assign cmd        = decode_key(wr_data);
    assign presc_done = presc_ack_s != presc_seen;
    assign rld_done   = rld_ack_s != rld_seen;
    assign wr_cmd     = wr_en && (reg_sel_e'(wr_sel) == SEL_CMD);
    assign wr_psc     = wr_en && (reg_sel_e'(wr_sel) == SEL_PSC) && unlocked && !presc_busy;
    assign wr_rld     = wr_en && (reg_sel_e'(wr_sel) == SEL_RLD) && unlocked && !rld_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked   <= 1'b0;
            presc_sh   <= '0;
            rld_sh     <= '1;
            presc_busy <= 1'b0;
            rld_busy   <= 1'b0;
            presc_seen <= 1'b0;
            rld_seen   <= 1'b0;
            req_tgl    <= '0;
        end else begin
            if (presc_done) begin
                presc_busy <= 1'b0;
                presc_seen <= presc_ack_s;
            end
            if (rld_done) begin
                rld_busy <= 1'b0;
                rld_seen <= rld_ack_s;
            end
            if (wr_cmd) begin
                unlocked <= (cmd == CMD_UNLOCK);
                if (cmd == CMD_START)  req_tgl.start  <= ~req_tgl.start;
                if (cmd == CMD_RELOAD) req_tgl.reload <= ~req_tgl.reload;
            end
            if (wr_psc) begin
                presc_sh      <= wr_data[PSC_W-1:0];
                presc_busy    <= 1'b1;
                req_tgl.presc <= ~req_tgl.presc;
            end
            if (wr_rld) begin
                rld_sh      <= wr_data[RLD_W-1:0];
                rld_busy    <= 1'b1;
                req_tgl.rld <= ~req_tgl.rld;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_sel_e'(rd_sel))
            SEL_PSC:  rd_data[PSC_W-1:0] = presc_sh;
            SEL_RLD:  rd_data[RLD_W-1:0] = rld_sh;
            SEL_STAT: rd_data[1:0]       = {rld_busy, presc_busy};
            default:  rd_data            = '0;
        endcase
    end

endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
#(
    parameter int RLD_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             lclk,
    input  logic             lrst,
    input  xfer_t            req_tgl,
    input  logic [PSC_W-1:0] presc_src,
    input  logic [RLD_W-1:0] rld_src,
    output logic             presc_ack,
    output logic             rld_ack,
    output logic             running,
    output logic             wdt_rst
);

    localparam logic [RLD_W-1:0] CNT_ONE = RLD_W'(1);
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic [XFER_W-1:0] req_s_vec;
    xfer_t             req_s, req_q, ev;
    logic [PSC_W-1:0]  presc_act;
    logic [RLD_W-1:0]  rld_act;
    logic [DIV_W-1:0]  div_cnt;
    logic [DIV_W-1:0]  lim;
    logic [RLD_W-1:0]  count;

    wdg_sync #(.W(XFER_W), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk (lclk),
        .rst (lrst),
        .d   (req_tgl),
        .q   (req_s_vec)
    );

    assign req_s = xfer_t'(req_s_vec);
    assign ev    = req_s ^ req_q;
    assign lim   = div_limit(presc_act);

    always_ff @(posedge lclk) begin
        if (lrst) begin
            req_q     <= '0;
            presc_act <= '0;
            rld_act   <= '1;
            presc_ack <= 1'b0;
            rld_ack   <= 1'b0;
            running   <= 1'b0;
            div_cnt   <= '0;
            count     <= '1;
            wdt_rst   <= 1'b0;
        end else begin
            req_q   <= req_s;
            wdt_rst <= 1'b0;
            if (ev.presc) begin
                presc_act <= presc_src;
                presc_ack <= ~presc_ack;
            end
            if (ev.rld) begin
                rld_act <= rld_src;
                rld_ack <= ~rld_ack;
            end
            if (ev.start && !running) begin
                running <= 1'b1;
                div_cnt <= '0;
                count   <= rld_act;
            end else if (ev.reload) begin
                div_cnt <= '0;
                count   <= rld_act;
            end else if (running) begin
                if (div_cnt >= lim) begin
                    div_cnt <= '0;
                    if (count == '0) begin
                        wdt_rst <= 1'b1;
                        count   <= rld_act;
                    end else begin
                        count <= count - CNT_ONE;
                    end
                end else begin
                    div_cnt <= div_cnt + DIV_ONE;
                end
            end
        end
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdg_pkg::*;
#(
    parameter int RLD_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [15:0] rd_data,
    input  logic        lclk,
    input  logic        lrst,
    output logic        wdt_rst
);

    xfer_t            req_tgl;
    logic [PSC_W-1:0] presc_sh;
    logic [RLD_W-1:0] rld_sh;
    logic             presc_busy, rld_busy, unlocked;
    logic             presc_ack, rld_ack;
    logic [1:0]       ack_s;
    logic             running;

    wdg_bus_regs #(.RLD_W(RLD_W)) u_bus (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .presc_ack_s (ack_s[0]),
        .rld_ack_s   (ack_s[1]),
        .req_tgl     (req_tgl),
        .presc_sh    (presc_sh),
        .rld_sh      (rld_sh),
        .presc_busy  (presc_busy),
        .rld_busy    (rld_busy),
        .unlocked    (unlocked)
    );

    wdg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   ({rld_ack, presc_ack}),
        .q   (ack_s)
    );

    wdg_core #(.RLD_W(RLD_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .lclk      (lclk),
        .lrst      (lrst),
        .req_tgl   (req_tgl),
        .presc_src (presc_sh),
        .rld_src   (rld_sh),
        .presc_ack (presc_ack),
        .rld_ack   (rld_ack),
        .running   (running),
        .wdt_rst   (wdt_rst)
    );

endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
    parameter int RLD_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             lclk,
    input logic             lrst,
    input logic             unlocked,
    input logic [2:0]       presc_sh,
    input logic [RLD_W-1:0] rld_sh,
    input logic             presc_busy,
    input logic             rld_busy,
    input logic             running,
    input logic             wdt_rst
);

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> ($stable(presc_sh) && $stable(rld_sh))); // R2

    AST_PSC_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        presc_busy |=> $stable(presc_sh)); // R3

    AST_RLD_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
        rld_busy |=> $stable(rld_sh)); // R3

    AST_PULSE_WIDTH: assert property (@(posedge lclk) disable iff (lrst)
        wdt_rst |=> !wdt_rst); // R7

    AST_IDLE_QUIET: assert property (@(posedge lclk) disable iff (lrst)
        !running |=> !wdt_rst); // R8

    AST_RUN_STICKY: assert property (@(posedge lclk) disable iff (lrst)
        running |=> running); // R10

endmodule

bind keyed_watchdog keyed_watchdog_chk #(.RLD_W(RLD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lclk       (lclk),
    .lrst       (lrst),
    .unlocked   (unlocked),
    .presc_sh   (presc_sh),
    .rld_sh     (rld_sh),
    .presc_busy (presc_busy),
    .rld_busy   (rld_busy),
    .running    (running),
    .wdt_rst    (wdt_rst)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;

    localparam int CLK_PERIOD  = 10;
    localparam int LCLK_PERIOD = 26;

    logic        clk = 1'b0, lclk = 1'b0;
    logic        rst = 1'b1, lrst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0, rd_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic        wdt_rst;

    int errors = 0;
    int checks = 0;
    int lcyc = 0, pulse_cnt = 0, last_pulse = 0, interval = 0;

    always #(CLK_PERIOD/2)  clk  = ~clk;
    always #(LCLK_PERIOD/2) lclk = ~lclk;

    keyed_watchdog u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .lclk(lclk), .lrst(lrst), .wdt_rst(wdt_rst)
    );

    always @(negedge lclk) begin
        lcyc = lcyc + 1;
        if (wdt_rst) begin
            interval   = lcyc - last_pulse;
            last_pulse = lcyc;
            pulse_cnt  = pulse_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output int d);
        @(negedge clk);
        rd_sel = sel;
        #1 d = int'(rd_data);
    endtask

    task automatic wait_idle(input string req);
        int s;
        s = 3;
        for (int i = 0; i < 60 && s != 0; i++) rd(2'd3, s);
        chk(req, s, 0);
    endtask

    task automatic configure(input int code, input int rv);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'(code));
        wait_idle("R4 prescaler busy clears");
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'(rv));
        wait_idle("R4 reload busy clears");
    endtask

    task automatic measure(input int code, input int rv);
        int p0, sh, expv;
        configure(code, rv);
        p0 = pulse_cnt;
        wait (pulse_cnt >= p0 + 2);
        sh   = (code > 6) ? 6 : code;
        expv = (4 << sh) * (rv + 1);
        chk($sformatf("R6 R7 period code=%0d reload=%0d", code, rv), interval, expv);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++; checks++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, p0;
        repeat (4) @(negedge lclk);
        @(negedge clk); rst = 1'b0;
        @(negedge lclk); lrst = 1'b0;

        // R1 reset state
        rd(2'd1, v); chk("R1 prescaler reset", v, 0);
        rd(2'd2, v); chk("R1 reload reset", v, 16'hFFF);
        rd(2'd3, v); chk("R1 status reset", v, 0);
        chk("R1 no pulse at reset", int'(wdt_rst), 0);

        // R2 locked writes ignored
        wr(2'd1, 16'd5);
        rd(2'd1, v); chk("R2 locked prescaler write", v, 0);
        wr(2'd2, 16'd3);
        rd(2'd2, v); chk("R2 locked reload write", v, 16'hFFF);

        // R3 busy flag and write while busy
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd2);
        rd(2'd3, v); chk("R3 prescaler busy set", v & 1, 1);
        wr(2'd1, 16'd4);
        wait_idle("R4 busy clears");
        rd(2'd1, v); chk("R3 write during busy ignored", v, 2);

        // R5 upper reload bits dropped
        wr(2'd2, 16'hF001);
        rd(2'd3, v); chk("R3 reload busy set", v & 2, 2);
        wait_idle("R4 reload busy clears");
        rd(2'd2, v); chk("R5 reload width", v, 1);

        // R2 other key relocks
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'd6);
        rd(2'd1, v); chk("R2 relocked by other key", v, 2);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hAAAA);
        wr(2'd1, 16'd6);
        rd(2'd1, v); chk("R2 relocked by reload key", v, 2);

        // R8 idle, reload key does not start
        wr(2'd0, 16'hAAAA);
        repeat (1500) @(negedge clk);
        chk("R8 no pulse while idle", pulse_cnt, 0);

        // start and sweep every prescaler code
        configure(0, 1);
        wr(2'd0, 16'hCCCC);
        for (int c = 0; c < 8; c++) measure(c, 1);
        measure(0, 5);
        measure(1, 5);
        measure(2, 0);

        // R9 refresh holds off the pulse
        measure(0, 20);
        p0 = pulse_cnt;
        for (int i = 0; i < 40; i++) begin
            wr(2'd0, 16'hAAAA);
            repeat (30) @(negedge clk);
        end
        chk("R9 refresh prevents pulse", pulse_cnt, p0);
        repeat (400) @(negedge clk);
        chk("R9 pulse after refresh stops", int'(pulse_cnt > p0), 1);

        // R10 cannot be stopped
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hFFFF);
        wr(2'd0, 16'hCCCC);
        p0 = pulse_cnt;
        repeat (400) @(negedge clk);
        chk("R10 still running", int'(pulse_cnt > p0), 1);
        p0 = pulse_cnt;
        wait (pulse_cnt >= p0 + 2);
        chk("R10 period unchanged", interval, 84);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule